// File: doc/BRIEF.md
# Biquad Coefficient Transfer Controller

This block moves 24-bit filter coefficients between a host-visible bank of byte registers and an on-chip coefficient memory. The memory holds the biquad, scaling and mixing terms that a filter datapath uses. The host builds each coefficient from three byte registers. The bank holds five such coefficients, which together form one biquad set. The host then writes a command.

A single-write command copies the first staged coefficient into memory at the base address. A block-write command copies all five staged coefficients to five consecutive memory words, starting at the base address. A single-read command fetches the word at the base address and places it in the first staged coefficient, where the host can read its bytes back. A biquad occupies five consecutive words. Channel 1 biquad 1 therefore sits at words 0 to 4 and biquad 2 starts at word 5. Scaling words are signed fractions: 0x800000 stands for -1 and 0x7FFFFF for just below +1.

The memory has one port, and the controller makes at most one access per clock. A busy flag shows when a command is running. Every host write that arrives while busy is dropped.

Top module: `coef_ram_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and `busy` is low.
- R2: The register map is as follows:
  - Address 0x00 holds the base address. Only its low ADDR_W bits (6 by default) are stored, and it reads back zero-extended.
  - Address 1+3*s+k holds staged coefficient s (s = 0..4). k=0 is bits 23:16, k=1 is bits 15:8 and k=2 is bits 7:0.
  - Address 0x10 is the command register.
  - Any other address reads 0x00.
  - `reg_rdata` shows the addressed register one clock after the clock that samples `reg_rd`.
- R3: Writing 1 to command bit 0 (single write) stores staged coefficient 0 at memory word `base`. `busy` stays high for exactly one clock.
- R4: Writing 1 to command bit 1 (block write) stores staged coefficients 0..4 at words base+0..base+4, one word per clock. `busy` stays high for exactly five clocks.
- R5: Writing 1 to command bit 2 (single read) loads memory word `base` into staged coefficient 0 and leaves coefficients 1..4 unchanged. `busy` stays high for exactly two clocks.
- R6: Word addresses base+k wrap modulo 2^ADDR_W.
- R7: While `busy` is high, every host register write is ignored. This covers the base address, the staged bytes and new commands.
- R8: The command bits clear themselves. The command register reads with bits 2:0 at zero, and bit 7 equals `busy`.
- R9: If several command bits are written at once, single write wins over block write, and block write wins over single read.
- R10: The controller never reads and writes the memory in the same clock. In a block write, each write uses the address one above the write before it.
- R11: The memory changes only through a write command. A command-register write with bits 2:0 all zero starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (5) | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| busy | output | 1 | Command in progress |

## Verification
Most faults inside the block surface only on a later read. Suppose an offset counter skips a step or the byte order inside a word is reversed. Nothing shows until the host issues a single read at that word, two clocks after the command plus one register read. So every memory write is followed by a read-back at each affected address. A wrong sequencer state, such as the wrong command chosen or a wrong end count, shows at once as a busy pulse of the wrong length: 1, 5 or 2 clocks. A write that leaks through while busy shows as changed base or staging bytes on the first idle read.

// File: rtl/coef_pkg.sv
package coef_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WR1   = 2'd1,
    OP_WRALL = 2'd2,
    OP_RD1   = 2'd3
  } coef_op_t;

  localparam int CMD_WR1_BIT   = 0;
  localparam int CMD_WRALL_BIT = 1;
  localparam int CMD_RD1_BIT   = 2;
  localparam int CMD_W         = 3;
  localparam int BUSY_BIT      = 7;
  localparam int BYTE_W        = 8;

  // Fixed priority: single write, then block write, then single read.
  function automatic coef_op_t pick_op(input logic [CMD_W-1:0] bits);
    if (bits[CMD_WR1_BIT])        return OP_WR1;
    else if (bits[CMD_WRALL_BIT]) return OP_WRALL;
    else if (bits[CMD_RD1_BIT])   return OP_RD1;
    else                          return OP_IDLE;
  endfunction

endpackage

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int AW = 6,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single-port synchronous array, written so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end
endmodule

// File: rtl/coef_seq.sv
module coef_seq
  import coef_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NSETS = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [CMD_W-1:0]         cmd_bits,
  input  logic [AW-1:0]            base,
  output logic                     busy,
  output logic                     ram_we,
  output logic                     ram_re,
  output logic [AW-1:0]            ram_addr,
  output logic [$clog2(NSETS)-1:0] set_sel,
  output logic                     load_first
);
  localparam int CW = $clog2(NSETS);

  coef_op_t      op_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          last;
  coef_op_t      op_new;

  assign op_new = pick_op(cmd_bits);

  always_comb begin
    case (op_q)
      OP_WR1:   last = 1'b1;
      OP_WRALL: last = (cnt_q == CW'(NSETS - 1));
      OP_RD1:   last = (cnt_q == CW'(1));
      default:  last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (cmd_valid && op_new != OP_IDLE) begin
        busy_q <= 1'b1;
        op_q   <= op_new;
        cnt_q  <= '0;
      end
    end else if (last) begin
      busy_q <= 1'b0;
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy       = busy_q;
  assign ram_we     = busy_q && (op_q == OP_WR1 || op_q == OP_WRALL);
  assign ram_re     = busy_q && (op_q == OP_RD1) && (cnt_q == '0);
  assign load_first = busy_q && (op_q == OP_RD1) && (cnt_q == CW'(1));
  assign ram_addr   = base + AW'(cnt_q);
  assign set_sel    = cnt_q;
endmodule

// File: rtl/coef_stage.sv
module coef_stage
  import coef_pkg::*;
#(
  parameter int NSETS  = 5,
  parameter int COEF_W = 24
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         byte_we,
  input  logic [$clog2(NSETS*(COEF_W/BYTE_W))-1:0]     byte_sel,
  input  logic [BYTE_W-1:0]                            byte_wdata,
  input  logic                                         load_first,
  input  logic [COEF_W-1:0]                            load_word,
  input  logic [$clog2(NSETS)-1:0]                     rd_sel,
  output logic [NSETS*COEF_W-1:0]                      flat,
  output logic [COEF_W-1:0]                            sel_word
);
  localparam int NBYTES = COEF_W / BYTE_W;
  localparam int NREGS  = NSETS * NBYTES;
  localparam int SELW   = $clog2(NREGS);

  logic [COEF_W-1:0] coef_q [NSETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) coef_q[s] <= '0;
    end else begin
      for (int s = 0; s < NSETS; s++) begin
        for (int b = 0; b < NBYTES; b++) begin
          // Byte 0 of a set is the most significant byte.
          if (byte_we && byte_sel == SELW'(s * NBYTES + b))
            coef_q[s][(NBYTES-1-b)*BYTE_W +: BYTE_W] <= byte_wdata;
        end
      end
      if (load_first) coef_q[0] <= load_word;
    end
  end

  for (genvar g = 0; g < NSETS; g++) begin : g_flat
    assign flat[g*COEF_W +: COEF_W] = coef_q[g];
  end

  assign sel_word = (int'(rd_sel) < NSETS) ? coef_q[rd_sel] : '0;
endmodule

// File: rtl/coef_regif.sv
module coef_regif
  import coef_pkg::*;
#(
  parameter int AW     = 6,
  parameter int NSETS  = 5,
  parameter int COEF_W = 24,
  parameter int REG_AW = 5
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     reg_wr,
  input  logic                                     reg_rd,
  input  logic [REG_AW-1:0]                        reg_addr,
  input  logic [BYTE_W-1:0]                        reg_wdata,
  output logic [BYTE_W-1:0]                        reg_rdata,
  input  logic                                     busy,
  input  logic [NSETS*COEF_W-1:0]                  stage_flat,
  output logic [AW-1:0]                            base,
  output logic                                     cmd_valid,
  output logic [CMD_W-1:0]                         cmd_bits,
  output logic                                     byte_we,
  output logic [$clog2(NSETS*(COEF_W/BYTE_W))-1:0] byte_sel,
  output logic [BYTE_W-1:0]                        byte_wdata
);
  localparam int NBYTES    = COEF_W / BYTE_W;
  localparam int NREGS     = NSETS * NBYTES;
  localparam int SELW      = $clog2(NREGS);
  localparam int CTRL_ADDR = NREGS + 1;

  logic              wr_ok;
  logic [AW-1:0]     base_q;
  logic [BYTE_W-1:0] rd_next;

  assign wr_ok = reg_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst)                               base_q <= '0;
    else if (wr_ok && reg_addr == '0)      base_q <= reg_wdata[AW-1:0];
  end
  assign base = base_q;

  assign byte_we    = wr_ok && (reg_addr >= REG_AW'(1)) && (reg_addr <= REG_AW'(NREGS));
  assign byte_sel   = SELW'(reg_addr - REG_AW'(1));
  assign byte_wdata = reg_wdata;
  assign cmd_valid  = wr_ok && (reg_addr == REG_AW'(CTRL_ADDR));
  assign cmd_bits   = reg_wdata[CMD_W-1:0];

  always_comb begin
    rd_next = '0;
    if (reg_addr == '0) rd_next = BYTE_W'(base_q);
    for (int i = 0; i < NREGS; i++) begin
      if (reg_addr == REG_AW'(i + 1))
        rd_next = stage_flat[(i / NBYTES) * COEF_W + (NBYTES - 1 - (i % NBYTES)) * BYTE_W +: BYTE_W];
    end
    if (reg_addr == REG_AW'(CTRL_ADDR)) begin
      rd_next           = '0;
      rd_next[BUSY_BIT] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/coef_ram_ctrl.sv
module coef_ram_ctrl
  import coef_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int COEF_W = 24,
  parameter int NSETS  = 5,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              busy
);
  localparam int NBYTES = COEF_W / BYTE_W;
  localparam int SELW   = $clog2(NSETS * NBYTES);
  localparam int CW     = $clog2(NSETS);

  logic [ADDR_W-1:0]       base_q;
  logic                    cmd_valid;
  logic [CMD_W-1:0]        cmd_bits;
  logic                    byte_we;
  logic [SELW-1:0]         byte_sel;
  logic [BYTE_W-1:0]       byte_wdata;
  logic [NSETS*COEF_W-1:0] stage_flat;
  logic [COEF_W-1:0]       sel_word;
  logic                    ram_we;
  logic                    ram_re;
  logic [ADDR_W-1:0]       ram_addr;
  logic [CW-1:0]           set_sel;
  logic                    load_first;
  logic [COEF_W-1:0]       ram_rdata;

  coef_regif #(.AW(ADDR_W), .NSETS(NSETS), .COEF_W(COEF_W), .REG_AW(REG_AW)) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .stage_flat(stage_flat),
    .base(base_q), .cmd_valid(cmd_valid), .cmd_bits(cmd_bits), .byte_we(byte_we),
    .byte_sel(byte_sel), .byte_wdata(byte_wdata)
  );

  coef_stage #(.NSETS(NSETS), .COEF_W(COEF_W)) u_stage (
    .clk(clk), .rst(rst), .byte_we(byte_we), .byte_sel(byte_sel), .byte_wdata(byte_wdata),
    .load_first(load_first), .load_word(ram_rdata), .rd_sel(set_sel),
    .flat(stage_flat), .sel_word(sel_word)
  );

  coef_seq #(.AW(ADDR_W), .NSETS(NSETS)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_bits(cmd_bits), .base(base_q),
    .busy(busy), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .set_sel(set_sel), .load_first(load_first)
  );

  coef_ram #(.AW(ADDR_W), .DW(COEF_W)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(sel_word), .rdata(ram_rdata)
  );
endmodule

// File: rtl/coef_ram_ctrl_chk.sv
module coef_ram_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int NSETS  = 5,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ram_we,
  input logic              ram_re,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata
);
  localparam int CTRL_ADDR = NSETS * 3 + 1;

  int run_q;
  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  assert_one_access_R10: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  assert_step_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

  assert_access_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> busy);

  assert_cmd_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr && reg_addr == REG_AW'(CTRL_ADDR) && reg_wdata[2:0] != 3'b000) |=> busy);

  assert_base_hold_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(base_q));

  assert_busy_max_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < NSETS));
endmodule

bind coef_ram_ctrl coef_ram_ctrl_chk #(.ADDR_W(ADDR_W), .NSETS(NSETS), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ram_we(ram_we), .ram_re(ram_re),
  .ram_addr(ram_addr), .base_q(base_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/sim_coef_ram_ctrl.sv
module sim_coef_ram_ctrl;
  localparam logic [4:0] A_BASE = 5'h00;
  localparam logic [4:0] A_CTRL = 5'h10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  coef_ram_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_coef(input int s, input logic [23:0] v);
    wr(5'(1 + 3*s), v[23:16]);
    wr(5'(2 + 3*s), v[15:8]);
    wr(5'(3 + 3*s), v[7:0]);
  endtask

  task automatic get_coef(input int s, output logic [23:0] v);
    logic [7:0] b;
    rd(5'(1 + 3*s), b); v[23:16] = b;
    rd(5'(2 + 3*s), b); v[15:8]  = b;
    rd(5'(3 + 3*s), b); v[7:0]   = b;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [7:0] bits, output int n);
    wr(A_CTRL, bits);
    wait_idle(n);
  endtask

  task automatic fetch(input logic [5:0] addr, output logic [23:0] v);
    int n;
    wr(A_BASE, {2'b00, addr});
    cmd(8'h04, n);
    get_coef(0, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 busy after reset", busy, 0);
    for (int a = 0; a <= 16; a++) begin
      rd(5'(a), d);
      chk("R1 register after reset", d, 0);
    end
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    logic [23:0] v;
    wr(A_BASE, 8'hFF);
    rd(A_BASE, d);
    chk("R2 base keeps low 6 bits", d, 8'h3F);
    set_coef(4, 24'hC1D2E3);
    wr(5'd4, 8'h5A);
    rd(5'd13, d); chk("R2 set4 byte hi at 0x0D", d, 8'hC1);
    rd(5'd15, d); chk("R2 set4 byte lo at 0x0F", d, 8'hE3);
    rd(5'd4, d);  chk("R2 set1 byte hi at 0x04", d, 8'h5A);
    get_coef(4, v); chk("R2 set4 word", v, 24'hC1D2E3);
    rd(5'h1F, d); chk("R2 unmapped reads zero", d, 8'h00);
  endtask

  task automatic t_single;
    int n;
    logic [23:0] v;
    set_coef(0, 24'h123456);
    set_coef(3, 24'h0F0F0F);
    wr(A_BASE, 8'd7);
    cmd(8'h01, n);
    chk("R3 single write busy length", n, 1);
    set_coef(0, 24'hABCDEF);
    cmd(8'h04, n);
    chk("R5 single read busy length", n, 2);
    get_coef(0, v); chk("R3 word stored at base / R5 loaded into set0", v, 24'h123456);
    get_coef(3, v); chk("R5 other sets unchanged", v, 24'h0F0F0F);
  endtask

  task automatic t_block(input logic [5:0] b, input logic [23:0] salt, input string req);
    int n;
    logic [23:0] v;
    logic [23:0] pats [5];
    pats[0] = 24'h800000; pats[1] = 24'h7FFFFF; pats[2] = 24'h000001;
    pats[3] = 24'hA5A5A5 ^ salt; pats[4] = 24'h3C3C3C ^ salt;
    for (int s = 0; s < 5; s++) set_coef(s, pats[s]);
    wr(A_BASE, {2'b00, b});
    cmd(8'h02, n);
    chk("R4 R10 block write busy five clocks", n, 5);
    for (int k = 0; k < 5; k++) begin
      fetch(6'(b + 6'(k)), v);
      chk(req, v, pats[k]);
    end
  endtask

  task automatic t_busy_ignore;
    int n;
    logic [7:0] d;
    logic [23:0] v;
    set_coef(0, 24'h444444);
    set_coef(2, 24'h222222);
    wr(A_BASE, 8'd20);
    wr(A_CTRL, 8'h02);
    wr(A_BASE, 8'd33);
    wr(5'd7, 8'h99);
    wr(A_CTRL, 8'h04);
    rd(A_CTRL, d);
    chk("R8 busy bit set while running", d, 8'h80);
    wait_idle(n);
    rd(A_BASE, d);
    chk("R7 base write ignored while busy", d, 8'd20);
    get_coef(2, v);
    chk("R7 staging write ignored while busy", v, 24'h222222);
    get_coef(0, v);
    chk("R7 read command ignored while busy", v, 24'h444444);
    rd(A_CTRL, d);
    chk("R8 command bits self-clear", d, 8'h00);
  endtask

  task automatic t_priority;
    int n;
    logic [23:0] v;
    set_coef(0, 24'h010203);
    wr(A_BASE, 8'd40);
    cmd(8'h07, n);
    chk("R9 single write wins over others", n, 1);
    set_coef(0, 24'h000000);
    fetch(6'd40, v);
    chk("R9 single write stored set0", v, 24'h010203);
    wr(A_BASE, 8'd45);
    cmd(8'h06, n);
    chk("R9 block write wins over read", n, 5);
  endtask

  task automatic t_no_cmd;
    int n;
    logic [23:0] v;
    set_coef(0, 24'h777777);
    wr(A_BASE, 8'd40);
    wr(A_CTRL, 8'h00);
    chk("R11 empty command leaves idle", busy, 0);
    wait_idle(n);
    fetch(6'd40, v);
    chk("R11 memory unchanged without write command", v, 24'h010203);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_single();
    t_block(6'd10, 24'h000000, "R4 block word at base+k");
    t_block(6'd62, 24'h111111, "R6 block address wraps");
    t_busy_ignore();
    t_priority();
    t_no_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule